// File: doc/BRIEF.md
# Column Offset Noise Corrector

This block sits in a pixel stream of unsigned samples that arrive one per clock, framed by a line-valid and a frame-valid marker. It removes the fixed offset that each sensor column adds to every pixel. The block learns that offset itself. A calibration pass is run while the sensor is kept dark. During the pass, each column's pixel values are summed over a fixed power-of-two number of lines. The block then keeps the integer mean of each column as an 8-bit coefficient in an internal table.

In correction mode, the coefficient for the current column is subtracted from each incoming pixel, and the result saturates at zero. A small control word selects the mode and arms calibration. The start bit clears itself once the pass has finished. Two sticky flags report dark pixels that fell outside the range an 8-bit coefficient can represent.

Top module: `fpn_column_corrector`

## Requirements
- R1: After reset, out_pix, out_lval, out_fval, ctl_rdata and both flags are 0, and every coefficient is 0. Correction before any calibration therefore returns the input unchanged.
- R2: out_pix, out_lval and out_fval are the result for the input sampled one clock edge earlier.
- R3: Control bits [1:0] select the mode. 01 subtracts the coefficients. 00, 10 and 11 pass pixels through unchanged. ctl_rdata returns {start bit, mode}.
- R4: In mode 01, a pixel in column c (counted from 0 at the start of each line) is output as max(pixel − coef[c], 0).
- R5: Writing control bit [2] as 1 arms calibration. The pass begins at the next rising edge of in_fval. Lines of a frame that was already open when the bit was written are not used.
- R6: After a pass, coef[c] = floor(S / 2^CAL_LINES_LOG2). S is the sum over the pass lines of column c's pixels, with each pixel first limited to 255. Lines are counted by line-valid falling edges, across frames if needed.
- R7: The start bit reads back as 1 during the pass. It returns to 0 at the clock edge that sees the falling edge of line-valid for the last pass line.
- R8: During a pass, a counted pixel equal to 0 sets flag_under and a counted pixel above 255 sets flag_over. Both flags hold until a control write with bit [2] = 1 clears them.
- R9: While a pass runs, pixels are output unchanged whatever the mode.
- R10: Pixels at column index NUM_COLS or higher in a line pass through uncorrected. They neither contribute to the sums nor raise flags. Calibration therefore needs full-width lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_pix | input | PIX_W | Incoming pixel value |
| in_lval | input | 1 | Line valid for in_pix |
| in_fval | input | 1 | Frame valid |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | [1:0] mode, [2] calibration start |
| ctl_rdata | output | 3 | {start bit, mode} |
| out_pix | output | PIX_W | Corrected pixel |
| out_lval | output | 1 | Line valid, delayed one clock |
| out_fval | output | 1 | Frame valid, delayed one clock |
| flag_under | output | 1 | Sticky: a dark pixel of 0 was seen |
| flag_over | output | 1 | Sticky: a dark pixel above 255 was seen |

## Verification
Every pixel result appears one clock edge after the pixel is presented. The bench presents each input on a falling edge and reads the matching output shortly after the next rising edge, so each comparison pairs one input with its own result. The start bit and the flags change at the same edge that samples the line-end or offending pixel cycle. They are read at the same point, right after the gap cycle that closes each line. Coefficients written during the last pass line take effect on the first line after the pass, and that is the first line checked for correction.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
   typedef enum logic [1:0] {
      CORR_OFF     = 2'b00,
      CORR_OFFLINE = 2'b01,
      CORR_RSVD    = 2'b10,
      CORR_ONLINE  = 2'b11
   } corr_mode_e;

   typedef enum logic {
      CAL_IDLE = 1'b0,
      CAL_RUN  = 1'b1
   } cal_state_e;
endpackage

// File: rtl/fcc_line_track.sv
module fcc_line_track #(
   parameter int NUM_COLS = 2096,
   localparam int COL_W = $clog2(NUM_COLS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lval,
   input  logic             fval,
   output logic [COL_W-1:0] col,
   output logic             col_ok,
   output logic             line_end,
   output logic             frame_rise
);
   logic lval_q, fval_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lval_q <= 1'b0;
         fval_q <= 1'b0;
         col    <= '0;
      end else begin
         lval_q <= lval;
         fval_q <= fval;
         if (!lval)
            col <= '0;
         else if (col != COL_W'(NUM_COLS))
            col <= col + 1'b1;
      end
   end

   assign col_ok     = lval && (col < COL_W'(NUM_COLS));
   assign line_end   = lval_q && !lval;
   assign frame_rise = fval && !fval_q;
endmodule

// File: rtl/fcc_cal_engine.sv
module fcc_cal_engine
   import fcc_pkg::*;
#(
   parameter int PIX_W          = 12,
   parameter int COEF_W         = 8,
   parameter int NUM_COLS       = 2096,
   parameter int CAL_LINES_LOG2 = 10,
   localparam int IDX_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
   localparam int SUM_W = COEF_W + CAL_LINES_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              frame_rise,
   input  logic              line_end,
   input  logic              pix_ok,
   input  logic [IDX_W-1:0]  idx,
   input  logic [PIX_W-1:0]  pix,
   output logic              run,
   output logic              done,
   output logic              coef_we,
   output logic [IDX_W-1:0]  coef_waddr,
   output logic [COEF_W-1:0] coef_wdata,
   output logic              under_hit,
   output logic              over_hit
);
   localparam logic [PIX_W-1:0] CLAMP = PIX_W'((1 << COEF_W) - 1);

   cal_state_e                state_q;
   logic [CAL_LINES_LOG2-1:0] line_q;
   logic [SUM_W-1:0]          sum_mem [NUM_COLS];
   logic [SUM_W-1:0]          base, acc;
   logic [COEF_W-1:0]         pix_lim;
   logic                      first_line, last_line, take;

   assign run        = (state_q == CAL_RUN);
   assign first_line = (line_q == '0);
   assign last_line  = &line_q;
   assign take       = run && pix_ok;
   assign over_hit   = take && (pix > CLAMP);
   assign under_hit  = take && (pix == '0);
   assign pix_lim    = (pix > CLAMP) ? '1 : pix[COEF_W-1:0];
   assign base       = first_line ? '0 : sum_mem[idx];
   assign acc        = base + SUM_W'(pix_lim);
   assign done       = run && line_end && last_line;
   assign coef_we    = take && last_line;
   assign coef_waddr = idx;
   assign coef_wdata = acc[SUM_W-1 -: COEF_W];

   always_ff @(posedge clk) begin
      if (take)
         sum_mem[idx] <= acc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CAL_IDLE;
         line_q  <= '0;
      end else begin
         case (state_q)
            CAL_IDLE: if (go && frame_rise) begin
               state_q <= CAL_RUN;
               line_q  <= '0;
            end
            default: if (line_end) begin
               if (last_line) state_q <= CAL_IDLE;
               else           line_q  <= line_q + 1'b1;
            end
         endcase
      end
   end

   // R5: a pass only begins on the frame edge that the tracker reported
   a_r5_start_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(frame_rise) && $past(go));
endmodule

// File: rtl/fcc_coef_store.sv
module fcc_coef_store #(
   parameter int NUM_COLS = 2096,
   parameter int COEF_W   = 8,
   localparam int IDX_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [COEF_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [COEF_W-1:0] rdata
);
   logic [COEF_W-1:0] mem [NUM_COLS];

   for (genvar i = 0; i < NUM_COLS; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (we && (waddr == IDX_W'(i)))
            mem[i] <= wdata;
      end
   end

   assign rdata = mem[raddr];

   // R10: the engine only writes columns inside the line width
   a_r10_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(waddr) < NUM_COLS));
endmodule

// File: rtl/fcc_sub_stage.sv
module fcc_sub_stage #(
   parameter int PIX_W  = 12,
   parameter int COEF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  pix,
   input  logic              lval,
   input  logic              fval,
   input  logic              apply,
   input  logic [COEF_W-1:0] coef,
   output logic [PIX_W-1:0]  out_pix,
   output logic              out_lval,
   output logic              out_fval
);
   logic [PIX_W:0]   diff;
   logic [PIX_W-1:0] res;

   assign diff = {1'b0, pix} - (PIX_W + 1)'(coef);
   assign res  = !apply ? pix : (diff[PIX_W] ? '0 : diff[PIX_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_pix  <= '0;
         out_lval <= 1'b0;
         out_fval <= 1'b0;
      end else begin
         out_pix  <= res;
         out_lval <= lval;
         out_fval <= fval;
      end
   end

   // R4: the output never exceeds the pixel it came from
   a_r4_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      out_lval |-> (out_pix <= $past(pix)));
endmodule

// File: rtl/fpn_column_corrector.sv
module fpn_column_corrector
   import fcc_pkg::*;
#(
   parameter int PIX_W          = 12,
   parameter int COEF_W         = 8,
   parameter int NUM_COLS       = 2096,
   parameter int CAL_LINES_LOG2 = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] in_pix,
   input  logic             in_lval,
   input  logic             in_fval,
   input  logic             ctl_we,
   input  logic [2:0]       ctl_wdata,
   output logic [2:0]       ctl_rdata,
   output logic [PIX_W-1:0] out_pix,
   output logic             out_lval,
   output logic             out_fval,
   output logic             flag_under,
   output logic             flag_over
);
   localparam int IDX_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
   localparam int COL_W = $clog2(NUM_COLS + 1);

   if (PIX_W < COEF_W + 1) begin : g_bad_pix
      $error("PIX_W must exceed COEF_W");
   end
   if (CAL_LINES_LOG2 < 1 || CAL_LINES_LOG2 > 16) begin : g_bad_lines
      $error("CAL_LINES_LOG2 out of range");
   end
   if (NUM_COLS < 2) begin : g_bad_cols
      $error("NUM_COLS must be at least 2");
   end

   corr_mode_e        mode_q;
   logic              go_q;
   logic [COL_W-1:0]  col;
   logic              col_ok, line_end, frame_rise;
   logic              run, done, coef_we, under_hit, over_hit, apply;
   logic [IDX_W-1:0]  idx, coef_waddr;
   logic [COEF_W-1:0] coef_wdata, coef_rd;

   assign idx = col[IDX_W-1:0];

   fcc_line_track #(.NUM_COLS(NUM_COLS)) u_track (
      .clk(clk), .rst_n(rst_n), .lval(in_lval), .fval(in_fval),
      .col(col), .col_ok(col_ok), .line_end(line_end), .frame_rise(frame_rise));

   fcc_cal_engine #(.PIX_W(PIX_W), .COEF_W(COEF_W), .NUM_COLS(NUM_COLS),
                    .CAL_LINES_LOG2(CAL_LINES_LOG2)) u_cal (
      .clk(clk), .rst_n(rst_n), .go(go_q), .frame_rise(frame_rise),
      .line_end(line_end), .pix_ok(col_ok), .idx(idx), .pix(in_pix),
      .run(run), .done(done), .coef_we(coef_we), .coef_waddr(coef_waddr),
      .coef_wdata(coef_wdata), .under_hit(under_hit), .over_hit(over_hit));

   fcc_coef_store #(.NUM_COLS(NUM_COLS), .COEF_W(COEF_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(coef_waddr),
      .wdata(coef_wdata), .raddr(idx), .rdata(coef_rd));

   assign apply = (mode_q == CORR_OFFLINE) && !run && col_ok;

   fcc_sub_stage #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_sub (
      .clk(clk), .rst_n(rst_n), .pix(in_pix), .lval(in_lval), .fval(in_fval),
      .apply(apply), .coef(coef_rd), .out_pix(out_pix), .out_lval(out_lval),
      .out_fval(out_fval));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= CORR_OFF;
         go_q       <= 1'b0;
         flag_under <= 1'b0;
         flag_over  <= 1'b0;
      end else begin
         if (done) go_q <= 1'b0;
         if (ctl_we) begin
            mode_q <= corr_mode_e'(ctl_wdata[1:0]);
            if (ctl_wdata[2]) begin
               go_q       <= 1'b1;
               flag_under <= 1'b0;
               flag_over  <= 1'b0;
            end
         end
         if (under_hit) flag_under <= 1'b1;
         if (over_hit)  flag_over  <= 1'b1;
      end
   end

   assign ctl_rdata = {go_q, mode_q};

   // R7: the start bit only drops when the engine finishes its last line
   a_r7_go_clears_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(go_q) |-> $past(done));
   // R8: flags only drop on a start write
   a_r8_over_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_over) |-> $past(ctl_we && ctl_wdata[2]));
   a_r8_under_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_under) |-> $past(ctl_we && ctl_wdata[2]));
   // R5: a running pass always has its start bit set
   a_r5_run_has_go: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> go_q);
   // R3: modes other than 01 leave pixels unchanged
   a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (out_lval && $past(mode_q) != CORR_OFFLINE) |-> (out_pix == $past(in_pix)));
endmodule

// File: tb/fpn_column_corrector_tb_top.sv
module fpn_column_corrector_tb_top;
   localparam int PW = 12, CW = 8, NC = 8, LL2 = 2, NL = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic [PW-1:0] in_pix;
   logic          in_lval, in_fval, ctl_we;
   logic [2:0]    ctl_wdata, ctl_rdata;
   logic [PW-1:0] out_pix;
   logic          out_lval, out_fval, flag_under, flag_over;

   fpn_column_corrector #(.PIX_W(PW), .COEF_W(CW), .NUM_COLS(NC),
                          .CAL_LINES_LOG2(LL2)) dut_i (.*);

   int compared = 0, mismatched = 0;
   bit finished = 0;
   int coef_m [NC];
   int mode_m = 0;
   bit cal_m = 0;
   int lbuf [16];
   int cal_v [NL][16];

   task automatic chk(input int act, input int exp, input string what);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic drive(input int p, input bit lv, input bit fv);
      @(negedge clk);
      in_pix = PW'(p); in_lval = lv; in_fval = fv;
      @(posedge clk); #1;
   endtask

   task automatic wr(input int d);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = 3'(d);
      @(posedge clk); #1;
      ctl_we = 1'b0;
      mode_m = d & 3;
   endtask

   function automatic int exp_pix(input int v, input int i);
      if (mode_m == 1 && !cal_m && i < NC)
         return (v > coef_m[i]) ? v - coef_m[i] : 0;
      return v;
   endfunction

   task automatic send_line(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         drive(lbuf[i], 1'b1, 1'b1);
         chk(int'(out_pix), exp_pix(lbuf[i], i), req);
         chk(int'(out_lval), 1, "R2 lval delay");
      end
      drive(0, 1'b0, 1'b1);
      chk(int'(out_fval), 1, "R2 fval delay");
   endtask

   task automatic calc_coefs();
      for (int c = 0; c < NC; c++) begin
         int s = 0;
         for (int l = 0; l < NL; l++) s += (cal_v[l][c] > 255) ? 255 : cal_v[l][c];
         coef_m[c] = s / NL;
      end
   endtask

   task automatic cal_frame();
      drive(0, 1'b0, 1'b0);
      drive(0, 1'b0, 1'b1);
      cal_m = 1;
      for (int l = 0; l < NL; l++) begin
         for (int i = 0; i < 10; i++) lbuf[i] = cal_v[l][i];
         send_line(10, "R9 passthrough during pass");
         if (l < NL - 1) chk(int'(ctl_rdata[2]), 1, "R7 start bit held");
      end
      chk(int'(ctl_rdata[2]), 0, "R7 start bit cleared");
      cal_m = 0;
      calc_coefs();
      drive(0, 1'b0, 1'b0);
   endtask

   task automatic sweep(input int lines, input string req);
      drive(0, 1'b0, 1'b1);
      for (int k = 0; k < lines; k++) begin
         for (int c = 0; c < NC; c++) lbuf[c] = (k * 35 + c * 7 + k * k) % 4096;
         send_line(NC, req);
      end
      for (int c = 0; c < NC; c++) lbuf[c] = coef_m[c] - 1 + (c % 3);
      send_line(NC, "R4 saturation edge");
      drive(0, 1'b0, 1'b0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         compared++; mismatched++;
         $display("FAIL watchdog actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_pix = '0; in_lval = 1'b0; in_fval = 1'b0;
      ctl_we = 1'b0; ctl_wdata = '0;
      for (int c = 0; c < NC; c++) coef_m[c] = 0;
      repeat (3) @(posedge clk);
      #1;
      chk(int'(out_pix), 0, "R1 reset pix");
      chk(int'(out_lval), 0, "R1 reset lval");
      chk(int'(ctl_rdata), 0, "R1 reset ctl");
      chk(int'(flag_under) + int'(flag_over), 0, "R1 reset flags");
      @(negedge clk); rst_n = 1'b1;

      // R1: correction with zero coefficients
      wr(1);
      chk(int'(ctl_rdata), 1, "R3 readback");
      drive(0, 1'b0, 1'b1);
      for (int c = 0; c < NC; c++) lbuf[c] = 100 + c;
      send_line(NC, "R1 zero coefs");
      drive(0, 1'b0, 1'b0);

      // R5: arm while a frame is open; its lines must be ignored
      wr(0);
      drive(0, 1'b0, 1'b1);
      wr(4);
      for (int l = 0; l < 3; l++) begin
         for (int i = 0; i < 10; i++) lbuf[i] = 200 + i;
         send_line(10, "R5 open frame passthrough");
      end
      chk(int'(ctl_rdata[2]), 1, "R5 still armed");
      drive(0, 1'b0, 1'b0);
      for (int l = 0; l < NL; l++)
         for (int i = 0; i < 10; i++)
            cal_v[l][i] = (i < NC) ? 10 * i + 3 * l + 1 : 4000;
      cal_frame();
      chk(int'(flag_under), 0, "R10 no under flag");
      chk(int'(flag_over), 0, "R10 no over flag from extra columns");

      // R4, R6: correction sweep with learned coefficients
      wr(1);
      sweep(120, "R4 R6 correction");

      // R10: extra columns pass through
      drive(0, 1'b0, 1'b1);
      for (int i = 0; i < 10; i++) lbuf[i] = 500 + i;
      send_line(10, "R10 extra columns");
      drive(0, 1'b0, 1'b0);

      // R3: reserved and online codes pass through
      wr(3);
      drive(0, 1'b0, 1'b1);
      for (int c = 0; c < NC; c++) lbuf[c] = 90 + c;
      send_line(NC, "R3 mode 11");
      wr(2);
      send_line(NC, "R3 mode 10");
      drive(0, 1'b0, 1'b0);

      // R8, R9: second pass with out-of-range dark pixels, mode 01 set
      for (int l = 0; l < NL; l++)
         for (int i = 0; i < 10; i++)
            cal_v[l][i] = (i < NC) ? 50 + i + l : 4000;
      cal_v[1][0] = 0;
      cal_v[2][1] = 300;
      cal_v[0][2] = 4095;
      wr(5);
      cal_frame();
      chk(int'(flag_under), 1, "R8 under flag");
      chk(int'(flag_over), 1, "R8 over flag");
      sweep(20, "R6 clamped coefficients");
      chk(int'(flag_over), 1, "R8 flag sticky");
      wr(5);
      chk(int'(flag_under) + int'(flag_over), 0, "R8 flags cleared on start");
      chk(int'(ctl_rdata), 5, "R3 readback armed");

      finished = 1;
      summary();
      $finish;
   end
endmodule